// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Readout Port

This block is the digital face of a slow delta-sigma converter toward a host that reads it over a serial bus. The host drives a chip-select and a serial clock and listens on one data line. The block runs a fixed-length conversion timer. When the timer expires, it captures a result word into a static shift register and goes to sleep. It then waits for the host to clock the word out. While chip select is low and no readout is in progress, the data line reports status. It reads high while the block is busy and low once a result is waiting.

A readout starts with the first rising serial-clock edge seen in sleep. Each falling edge advances the line to the next bit, most significant first, so the host samples on rising edges. The 32nd falling edge ends the readout and starts a new conversion. Raising chip select part-way through a readout abandons it and also starts a new conversion. A strap sampled during reset selects a two-wire mode, in which chip select is treated as permanently asserted. All inputs are taken as synchronous to the block clock. Serial-clock edges are found by comparing the input with its value one clock earlier.

Top module: `adc_serial_port`

## Requirements
- R1: In four-wire mode, while `cs_n` is high, `sdo_oe` is 0 and `sdo` is 0 (high impedance).
- R2: With the line enabled and a conversion in progress, `sdo` is 1.
- R3: A conversion lasts exactly CONV_CYCLES clock cycles after the cycle in which `conv_start` is seen high. The block then enters sleep, and `sdo` reads 0 while enabled.
- R4: The word read out is the `conv_data` value present at the end of conversion, with bit 31 replaced by 0. Bit 31 is visible before the first rising serial-clock edge. Each falling edge during readout exposes the next lower bit, down to bit 0 after the 31st falling edge.
- R5: The 32nd falling serial-clock edge of a readout raises `conv_start` for exactly one cycle and sets `sdo` to 1.
- R6: Chip select rising after the first rising serial-clock edge and before the 32nd falling edge abandons the readout. A one-cycle `conv_start` follows, and the block is busy when next polled.
- R7: Chip select going high and low again during sleep, with no rising serial-clock edge while selected, keeps the held word intact. A full readout can still be made afterwards.
- R8: Serial-clock edges during a conversion do not shift data and keep `sdo` at 1. The conversion ends on schedule and the later readout is complete.
- R9: `mode_2w_sel` is captured while `rst` is high. When it was 1, `cs_n` is ignored, `sdo_oe` stays 1, and status and readout work as if chip select were low.
- R10: Changes of `conv_data` after the end of conversion do not alter the held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; starts a conversion when released |
| mode_2w_sel | input | 1 | Two-wire mode strap, captured during reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the host, idles low |
| conv_data | input | WORD_W | Result word captured at the end of a conversion |
| sdo | output | 1 | Serial data / status value |
| sdo_oe | output | 1 | Drive enable for the data line; 0 means high impedance |
| conv_start | output | 1 | One-cycle pulse when a new conversion begins after readout or abort |

## Verification
A wrong state in this block shows up on `sdo` within one clock of the next poll or serial-clock edge. A block stuck busy keeps the line high past the conversion length. A block that leaves sleep too early corrupts the first bit, because that bit must read 0. A bit counter that is off by one either moves the restart pulse by one falling edge or drops the low bit of the word. A missed abort shows as an absent `conv_start` one cycle after chip select rises. Edges that leak in during a conversion show as a shifted word at the next full readout.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

    typedef enum logic [1:0] {
        ST_CONV  = 2'd0,
        ST_SLEEP = 2'd1,
        ST_DATA  = 2'd2
    } sp_state_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } sck_ev_t;

    function automatic logic sp_shows_busy(input sp_state_t st);
        return st == ST_CONV;
    endfunction

endpackage

// File: rtl/adc_sp_edge.sv
module adc_sp_edge
    import adc_sp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sck,
    output sck_ev_t ev
);
    logic sck_q;

    always_ff @(posedge clk) begin
        if (rst) sck_q <= 1'b0;
        else     sck_q <= sck;
    end

    always_comb begin
        ev.rise = sck & ~sck_q;
        ev.fall = ~sck & sck_q;
    end
endmodule

// File: rtl/adc_sp_timer.sv
module adc_sp_timer #(
    parameter int CONV_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic tc
);
    localparam int CNT_W = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tc = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || start)    cnt_q <= '0;
        else if (run && !tc) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/adc_sp_shifter.sv
module adc_sp_shifter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] din,
    input  logic              shift,
    output logic [WORD_W-1:0] word,
    output logic              msb
);
    localparam logic [WORD_W-1:0] FLAG_BIT = {1'b1, {(WORD_W-1){1'b0}}};

    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst)        sh_q <= '0;
        else if (load)  sh_q <= din & ~FLAG_BIT;
        else if (shift) sh_q <= {sh_q[WORD_W-2:0], 1'b0};
    end

    assign word = sh_q;
    assign msb  = sh_q[WORD_W-1];
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
    import adc_sp_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int CONV_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_2w_sel,
    input  logic              cs_n,
    input  logic              sck,
    input  logic [WORD_W-1:0] conv_data,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              conv_start
);
    localparam int BIT_CNT_W = $clog2(WORD_W);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(WORD_W - 1);

    logic                 mode_q;
    logic                 sel;
    sck_ev_t              ev;
    sp_state_t            state_q, state_d;
    logic [BIT_CNT_W-1:0] bit_cnt_q, bit_cnt_d;
    logic                 go_conv;
    logic                 tc;
    logic                 shift;
    logic [WORD_W-1:0]    sh_word;
    logic                 sh_msb;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= mode_2w_sel;
    end

    assign sel = mode_q | ~cs_n;

    adc_sp_edge u_edge (
        .clk (clk),
        .rst (rst),
        .sck (sck),
        .ev  (ev)
    );

    adc_sp_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (go_conv),
        .run   (state_q == ST_CONV),
        .tc    (tc)
    );

    adc_sp_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (tc),
        .din   (conv_data),
        .shift (shift),
        .word  (sh_word),
        .msb   (sh_msb)
    );

    always_comb begin
        state_d   = state_q;
        bit_cnt_d = bit_cnt_q;
        go_conv   = 1'b0;
        shift     = 1'b0;
        case (state_q)
            ST_CONV: begin
                if (tc) state_d = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (sel && ev.rise) begin
                    state_d   = ST_DATA;
                    bit_cnt_d = '0;
                end
            end
            ST_DATA: begin
                if (!sel) begin
                    go_conv = 1'b1;
                    state_d = ST_CONV;
                end else if (ev.fall) begin
                    if (bit_cnt_q == LAST_BIT) begin
                        go_conv = 1'b1;
                        state_d = ST_CONV;
                    end else begin
                        shift     = 1'b1;
                        bit_cnt_d = bit_cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_CONV;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_CONV;
            bit_cnt_q  <= '0;
            conv_start <= 1'b0;
        end else begin
            state_q    <= state_d;
            bit_cnt_q  <= bit_cnt_d;
            conv_start <= go_conv;
        end
    end

    assign sdo_oe = sel;
    assign sdo    = sel & (sp_shows_busy(state_q) | sh_msb);
endmodule

// File: rtl/adc_sp_checker.sv
module adc_sp_checker
    import adc_sp_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              mode_q,
    input logic              sdo,
    input logic              sdo_oe,
    input logic              conv_start,
    input sp_state_t         state_q,
    input logic              tc,
    input logic [WORD_W-1:0] sh_word
);
    assert_hiz_R1: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && cs_n) |-> (!sdo_oe && !sdo));

    assert_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CONV && sdo_oe) |-> sdo);

    assert_sleep_low_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLEEP && sdo_oe) |-> !sdo);

    assert_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);

    assert_abort_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA && cs_n && !mode_q) |=> (conv_start && state_q == ST_CONV));

    assert_noshift_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CONV && !tc) |=> $stable(sh_word));

    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(mode_q));
endmodule

bind adc_serial_port adc_sp_checker #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .mode_q     (mode_q),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe),
    .conv_start (conv_start),
    .state_q    (state_q),
    .tc         (tc),
    .sh_word    (sh_word)
);

// File: tb/sim_adc_serial_port.sv
module sim_adc_serial_port;
    localparam int W = 32;
    localparam int N = 40;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_2w_sel = 1'b0;
    logic         cs_n = 1'b1;
    logic         sck = 1'b0;
    logic [W-1:0] conv_data = '0;
    logic         sdo, sdo_oe, conv_start;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    adc_serial_port #(.WORD_W(W), .CONV_CYCLES(N)) u0 (
        .clk         (clk),
        .rst         (rst),
        .mode_2w_sel (mode_2w_sel),
        .cs_n        (cs_n),
        .sck         (sck),
        .conv_data   (conv_data),
        .sdo         (sdo),
        .sdo_oe      (sdo_oe),
        .conv_start  (conv_start)
    );

    function automatic logic [W-1:0] held_of(input logic [W-1:0] d);
        return {1'b0, d[W-2:0]};
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Full readout from sleep, then the restart and conversion timing.
    task automatic read_all(input string tag, input logic [W-1:0] exp,
                            input logic [W-1:0] next_data);
        logic [W-1:0] got;
        got[W-1] = sdo;
        for (int j = 1; j < W; j++) begin
            sck = 1'b1; step();
            sck = 1'b0; step();
            got[W-1-j] = sdo;
        end
        chk({tag, " R4 word"}, got, exp);
        sck = 1'b1; step();
        sck = 1'b0; conv_data = next_data; step();
        chk("R5 start pulse", {31'd0, conv_start}, 32'd1);
        chk("R5 busy after last fall", {31'd0, sdo}, 32'd1);
        repeat (N - 1) step();
        chk("R3 busy at end", {31'd0, sdo}, 32'd1);
        step();
        chk("R3 sleep after length", {31'd0, sdo}, 32'd0);
        chk("R5 pulse single", {31'd0, conv_start}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog R3 actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        logic [W-1:0] nxt;
        void'($urandom(32'h5eed_1234));

        // reset, four-wire mode
        conv_data = 32'hDEAD_BEEF;
        repeat (3) step();
        chk("R1 oe in reset", {31'd0, sdo_oe}, 32'd0);
        chk("R1 sdo in reset", {31'd0, sdo}, 32'd0);
        chk("R5 no pulse in reset", {31'd0, conv_start}, 32'd0);
        rst = 1'b0; cs_n = 1'b0;
        step();
        chk("R2 oe on poll", {31'd0, sdo_oe}, 32'd1);
        chk("R2 busy on poll", {31'd0, sdo}, 32'd1);
        repeat (3) begin
            sck = 1'b1; step();
            sck = 1'b0; step();
        end
        chk("R8 busy kept under sck", {31'd0, sdo}, 32'd1);
        repeat (N - 1 - 7) step();
        chk("R3 busy before end", {31'd0, sdo}, 32'd1);
        step();
        chk("R3 sleep after reset conversion", {31'd0, sdo}, 32'd0);
        held = held_of(32'hDEAD_BEEF);
        conv_data = 32'h1234_5678;
        step();
        nxt = $urandom;
        read_all("R10 R8", held, nxt);
        held = held_of(nxt);

        // random trials
        for (int t = 0; t < 30; t++) begin
            int act;
            act = int'($urandom % 3);
            nxt = $urandom;
            if (t == 0) act = 1;
            if (act == 0) begin
                read_all("R4 random", held, nxt);
                held = held_of(nxt);
            end else if (act == 1) begin
                int k;
                k = (t == 0) ? 31 : int'($urandom % 32);
                for (int j = 1; j <= k; j++) begin
                    sck = 1'b1; step();
                    sck = 1'b0; step();
                    chk("R4 partial bit", {31'd0, sdo}, {31'd0, held[W-1-j]});
                end
                if (k == 0) begin
                    sck = 1'b1; step();
                    sck = 1'b0; step();
                end
                cs_n = 1'b1; conv_data = nxt; step();
                chk("R6 abort pulse", {31'd0, conv_start}, 32'd1);
                chk("R6 hiz on abort", {31'd0, sdo_oe}, 32'd0);
                cs_n = 1'b0; step();
                chk("R6 busy after abort", {31'd0, sdo}, 32'd1);
                repeat (N - 2) step();
                chk("R6 R3 busy at end", {31'd0, sdo}, 32'd1);
                step();
                chk("R6 R3 sleep", {31'd0, sdo}, 32'd0);
                held = held_of(nxt);
            end else begin
                cs_n = 1'b1; step();
                chk("R1 deselect in sleep", {31'd0, sdo_oe}, 32'd0);
                repeat (2) begin
                    sck = 1'b1; step();
                    sck = 1'b0; step();
                end
                chk("R7 no pulse on deselect", {31'd0, conv_start}, 32'd0);
                cs_n = 1'b0; step();
                chk("R7 still sleeping", {31'd0, sdo}, 32'd0);
                read_all("R7 reselect", held, nxt);
                held = held_of(nxt);
            end
        end

        // two-wire mode, chip select left high throughout
        rst = 1'b1; mode_2w_sel = 1'b1; cs_n = 1'b1;
        conv_data = 32'hFFFF_FFFF;
        repeat (2) step();
        rst = 1'b0; mode_2w_sel = 1'b0;
        step();
        chk("R9 oe with cs high", {31'd0, sdo_oe}, 32'd1);
        chk("R9 busy shown", {31'd0, sdo}, 32'd1);
        repeat (N) step();
        chk("R9 sleep shown", {31'd0, sdo}, 32'd0);
        read_all("R9 two-wire", held_of(32'hFFFF_FFFF), 32'h0F0F_A5A5);
        read_all("R9 second", held_of(32'h0F0F_A5A5), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule